// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the 256-byte configuration space of a PCI type-0 function and applies the write rules of each byte offset. Configuration writes arrive as a byte address, a size code and up to four data bytes. The whole write is applied in one clock cycle as a set of single-byte updates at increasing addresses. Each byte is then stored in full, masked, partly merged with its fixed bits, or dropped, depending on its offset. Bytes that would fall past offset 0xFF are discarded and never wrap to the start of the space.

Reads return the aligned dword one cycle after the read strobe. At reset the identity bytes load from parameters, and the subsystem identifier bytes load with the same values as the vendor and device identifiers. The storage is split into four byte-wide banks, one per byte position of a dword, so every bank takes at most one write per cycle, even for unaligned writes.

Top module: `cfg_space_regfile`

## Requirements
- R1: Synchronous reset (active high) loads vendor ID into 0x00–0x01, device ID into 0x02–0x03, status into 0x06–0x07, revision into 0x08, class code into 0x09–0x0B, header type into 0x0E and interrupt pin into 0x3D. It also copies the vendor ID into 0x2C–0x2D and the device ID into 0x2E–0x2F, and clears every other byte and `rd_data`.
- R2: Bytes 0x0B, 0x0E, 0x10–0x27, 0x2C–0x2F, 0x30–0x33 and 0x3D keep their value under any write.
- R3: A write to byte 0x05 stores data bits 2:0 and clears bits 7:3.
- R4: A write to byte 0x06 leaves it unchanged.
- R5: A write to byte 0x07 keeps stored bits 1 and 2 and takes bits 0 and 7:3 from the data.
- R6: Every byte not named in R2–R5 stores the written byte unchanged.
- R7: Size code 2'b00 writes one byte, 2'b01 two bytes and 2'b10 four bytes. Data byte i (`wr_data[8i+7:8i]`) goes to address `wr_addr+i`, and each byte follows the rule of its own offset. Size code 2'b11 writes nothing.
- R8: Any byte of a write whose address would exceed 0xFF is dropped, with no wrap to low addresses.
- R9: With `rd_en` high, `rd_data` takes, on the next edge, the dword at offsets `{rd_addr[7:2],2'b00}` to `+3`, little-endian (lowest offset in bits 7:0). `rd_addr[1:0]` is ignored. `rd_data` holds while `rd_en` is low.
- R10: A read issued in the cycle after a write returns the written values. A read issued in the same cycle as a write returns the values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the first written byte |
| wr_size | input | 2 | 00 byte, 01 word, 10 dword, 11 no write |
| wr_data | input | 32 | Write data, byte i to address wr_addr+i |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address, dword aligned on bits 7:2 |
| rd_data | output | 32 | Registered aligned dword |

## Verification
The bench builds the block with vendor 0x1A2B, device 0x3C4D, status 0x0290, revision 0x5E, class 0x0C0310, header type 0x80 and interrupt pin 0x02. The identity bytes are therefore nonzero and distinct, so a wrong byte order or a missed subsystem copy shows up on readback. Bit 1 of the status high byte is one and bit 2 is zero, so a merge that loses or inverts either bit is visible. It sweeps byte, word and dword writes across every one of the 256 start addresses, including the starts that cross 0xFF, against an arithmetic model of the offset rules.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int CFG_ADDR_W = 8;
  localparam int CFG_LANES  = 4;
  localparam int CFG_LANE_W = $clog2(CFG_LANES);
  localparam int CFG_BYTES  = 1 << CFG_ADDR_W;
  localparam int CFG_ROWS   = CFG_BYTES / CFG_LANES;
  localparam int CFG_ROW_W  = CFG_ADDR_W - CFG_LANE_W;

  localparam logic [7:0] OFS_CMD_HI  = 8'h05;
  localparam logic [7:0] OFS_STAT_LO = 8'h06;
  localparam logic [7:0] OFS_STAT_HI = 8'h07;
  localparam logic [7:0] CMD_HI_MASK = 8'h07;
  localparam logic [7:0] STAT_HI_FIX = 8'h06;

  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_WORD  = 2'b01;
  localparam logic [1:0] SZ_DWORD = 2'b10;

  typedef enum logic [2:0] {
    RULE_FULL,
    RULE_LOCKED,
    RULE_CMD_HI,
    RULE_KEEP,
    RULE_STAT_HI
  } byte_rule_e;

  function automatic byte_rule_e rule_of(input logic [7:0] a);
    if (a == OFS_CMD_HI)  return RULE_CMD_HI;
    if (a == OFS_STAT_LO) return RULE_KEEP;
    if (a == OFS_STAT_HI) return RULE_STAT_HI;
    if (a == 8'h0B || a == 8'h0E || a == 8'h3D) return RULE_LOCKED;
    if (a >= 8'h10 && a <= 8'h27) return RULE_LOCKED;
    if (a >= 8'h2C && a <= 8'h33) return RULE_LOCKED;
    return RULE_FULL;
  endfunction

  function automatic logic [CFG_LANES-1:0] lanes_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  return 4'b0001;
      SZ_WORD:  return 4'b0011;
      SZ_DWORD: return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(
    input logic [7:0]  a,
    input logic [15:0] ven,
    input logic [15:0] dev,
    input logic [7:0]  rev,
    input logic [23:0] cls,
    input logic [15:0] sts,
    input logic [7:0]  hdr,
    input logic [7:0]  pin
  );
    case (a)
      8'h00, 8'h2C: return ven[7:0];
      8'h01, 8'h2D: return ven[15:8];
      8'h02, 8'h2E: return dev[7:0];
      8'h03, 8'h2F: return dev[15:8];
      8'h06:        return sts[7:0];
      8'h07:        return sts[15:8];
      8'h08:        return rev;
      8'h09:        return cls[7:0];
      8'h0A:        return cls[15:8];
      8'h0B:        return cls[23:16];
      8'h0E:        return hdr;
      8'h3D:        return pin;
      default:      return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_lane_filter.sv
module cfg_lane_filter
  import cfg_space_pkg::*;
#(
  parameter int         LANE       = 0,
  parameter logic [7:0] STAT_HI_RV = 8'h00
) (
  input  logic                  wr_en,
  input  logic [CFG_ADDR_W-1:0] base_addr,
  input  logic [1:0]            wr_size,
  input  logic [7:0]            din,
  output logic                  lane_we,
  output logic [CFG_ADDR_W-1:0] lane_addr,
  output logic [7:0]            lane_val
);

  logic [CFG_ADDR_W:0] sum;
  logic                in_range;
  logic                selected;
  byte_rule_e          rule;

  assign sum       = {1'b0, base_addr} + (CFG_ADDR_W+1)'(LANE);
  assign in_range  = ~sum[CFG_ADDR_W];
  assign lane_addr = sum[CFG_ADDR_W-1:0];
  assign selected  = wr_en && lanes_of(wr_size)[LANE] && in_range;
  assign rule      = rule_of(lane_addr);

  always_comb begin
    lane_we  = 1'b0;
    lane_val = din;
    case (rule)
      RULE_FULL: lane_we = selected;
      RULE_CMD_HI: begin
        lane_we  = selected;
        lane_val = din & CMD_HI_MASK;
      end
      RULE_STAT_HI: begin
        lane_we  = selected;
        lane_val = (din & ~STAT_HI_FIX) | (STAT_HI_RV & STAT_HI_FIX);
      end
      default: lane_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfg_byte_bank.sv
module cfg_byte_bank
  import cfg_space_pkg::*;
#(
  parameter int          BANK      = 0,
  parameter logic [15:0] VENDOR_ID = 16'h0000,
  parameter logic [15:0] DEVICE_ID = 16'h0000,
  parameter logic [7:0]  REVISION  = 8'h00,
  parameter logic [23:0] CLASS     = 24'h000000,
  parameter logic [15:0] STATUS    = 16'h0000,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [CFG_ROW_W-1:0] wrow,
  input  logic [7:0]           wval,
  input  logic                 re,
  input  logic [CFG_ROW_W-1:0] rrow,
  output logic [7:0]           rdat
);

  logic [7:0] mem [CFG_ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < CFG_ROWS; r++) begin
        mem[r] <= reset_byte(8'(r*CFG_LANES + BANK), VENDOR_ID, DEVICE_ID,
                             REVISION, CLASS, STATUS, HDR_TYPE, INT_PIN);
      end
    end else if (we) begin
      mem[wrow] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdat <= 8'h00;
    else if (re) rdat <= mem[rrow];
  end

  for (genvar r = 0; r < CFG_ROWS; r++) begin : g_row_chk
    localparam logic [7:0] OFS = 8'(r*CFG_LANES + BANK);
    if (rule_of(OFS) == RULE_LOCKED) begin : g_locked
      // R2: protected bytes never move after reset
      a_r2_locked_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mem[r]));
    end else if (rule_of(OFS) == RULE_KEEP) begin : g_keep
      // R4: status low byte never moves after reset
      a_r4_keep_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mem[r]));
    end else if (rule_of(OFS) == RULE_CMD_HI) begin : g_cmd
      // R3: command high byte upper bits stay clear
      a_r3_cmd_hi_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mem[r][7:3] == 5'd0));
    end else if (rule_of(OFS) == RULE_STAT_HI) begin : g_sthi
      // R5: status high byte fixed bits keep their reset value
      a_r5_stat_hi_fixed: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((mem[r] & STAT_HI_FIX) == (STATUS[15:8] & STAT_HI_FIX)));
    end
  end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1234,
  parameter logic [15:0] DEVICE_ID = 16'h5678,
  parameter logic [7:0]  REVISION  = 8'h01,
  parameter logic [23:0] CLASS     = 24'h020000,
  parameter logic [15:0] STATUS    = 16'h0000,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h01
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [CFG_ADDR_W-1:0]       wr_addr,
  input  logic [1:0]                  wr_size,
  input  logic [CFG_LANES*8-1:0]      wr_data,
  input  logic                        rd_en,
  input  logic [CFG_ADDR_W-1:0]       rd_addr,
  output logic [CFG_LANES*8-1:0]      rd_data
);

  logic                  lane_we   [CFG_LANES];
  logic [CFG_ADDR_W-1:0] lane_addr [CFG_LANES];
  logic [7:0]            lane_val  [CFG_LANES];

  logic [CFG_LANES-1:0]  bank_we;
  logic [CFG_ROW_W-1:0]  bank_row  [CFG_LANES];
  logic [7:0]            bank_val  [CFG_LANES];
  logic [7:0]            bank_rdat [CFG_LANES];

  for (genvar i = 0; i < CFG_LANES; i++) begin : g_lane
    cfg_lane_filter #(
      .LANE       (i),
      .STAT_HI_RV (STATUS[15:8])
    ) u_filter (
      .wr_en     (wr_en),
      .base_addr (wr_addr),
      .wr_size   (wr_size),
      .din       (wr_data[8*i +: 8]),
      .lane_we   (lane_we[i]),
      .lane_addr (lane_addr[i]),
      .lane_val  (lane_val[i])
    );
  end

  for (genvar b = 0; b < CFG_LANES; b++) begin : g_bank
    localparam logic [CFG_LANE_W-1:0] BIDX = CFG_LANE_W'(b);
    logic [CFG_LANE_W-1:0] sel;

    always_comb begin
      sel         = BIDX - wr_addr[CFG_LANE_W-1:0];
      bank_we[b]  = lane_we[sel];
      bank_row[b] = lane_addr[sel][CFG_ADDR_W-1:CFG_LANE_W];
      bank_val[b] = lane_val[sel];
    end

    cfg_byte_bank #(
      .BANK      (b),
      .VENDOR_ID (VENDOR_ID),
      .DEVICE_ID (DEVICE_ID),
      .REVISION  (REVISION),
      .CLASS     (CLASS),
      .STATUS    (STATUS),
      .HDR_TYPE  (HDR_TYPE),
      .INT_PIN   (INT_PIN)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (bank_we[b]),
      .wrow (bank_row[b]),
      .wval (bank_val[b]),
      .re   (rd_en),
      .rrow (rd_addr[CFG_ADDR_W-1:CFG_LANE_W]),
      .rdat (bank_rdat[b])
    );

    assign rd_data[8*b +: 8] = bank_rdat[b];
  end

  // R8: a write starting at the last byte can reach at most one bank
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '1) |-> ($countones(bank_we) <= 1));

  // R7: size code 11 enables no bank
  a_r7_size_none: assert property (@(posedge clk) disable iff (rst)
    (wr_size == 2'b11) |-> (bank_we == '0));

  // R9: read data holds when no read was issued
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_cfg_space_regfile.sv
`timescale 1ns/1ps
module tb_cfg_space_regfile;

  localparam logic [15:0] T_VEN = 16'h1A2B;
  localparam logic [15:0] T_DEV = 16'h3C4D;
  localparam logic [7:0]  T_REV = 8'h5E;
  localparam logic [23:0] T_CLS = 24'h0C0310;
  localparam logic [15:0] T_STS = 16'h0290;
  localparam logic [7:0]  T_HDR = 8'h80;
  localparam logic [7:0]  T_PIN = 8'h02;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] model [256];

  always #4 clk = ~clk;

  cfg_space_regfile #(
    .VENDOR_ID (T_VEN), .DEVICE_ID (T_DEV), .REVISION (T_REV),
    .CLASS (T_CLS), .STATUS (T_STS), .HDR_TYPE (T_HDR), .INT_PIN (T_PIN)
  ) dut (
    .clk, .rst, .wr_en, .wr_addr, .wr_size, .wr_data,
    .rd_en, .rd_addr, .rd_data
  );

  function automatic bit is_locked(input int a);
    return a == 'h0B || a == 'h0E || a == 'h3D ||
           (a >= 'h10 && a <= 'h27) || (a >= 'h2C && a <= 'h33);
  endfunction

  function automatic string tag_of(input int a);
    if (is_locked(a)) return "R2";
    if (a == 5) return "R3";
    if (a == 6) return "R4";
    if (a == 7) return "R5";
    return "R6";
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    model['h00] = T_VEN[7:0];  model['h01] = T_VEN[15:8];
    model['h02] = T_DEV[7:0];  model['h03] = T_DEV[15:8];
    model['h06] = T_STS[7:0];  model['h07] = T_STS[15:8];
    model['h08] = T_REV;
    model['h09] = T_CLS[7:0];  model['h0A] = T_CLS[15:8]; model['h0B] = T_CLS[23:16];
    model['h0E] = T_HDR;       model['h3D] = T_PIN;
    model['h2C] = T_VEN[7:0];  model['h2D] = T_VEN[15:8];
    model['h2E] = T_DEV[7:0];  model['h2F] = T_DEV[15:8];
  endtask

  task automatic model_write(input int a, input int sz, input logic [31:0] d);
    int n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    for (int i = 0; i < n; i++) begin
      int t;
      logic [7:0] v;
      t = a + i;
      v = d[8*i +: 8];
      if (t > 255 || is_locked(t) || t == 6) continue;
      if (t == 5) model[t] = v & 8'h07;
      else if (t == 7) model[t] = (v & 8'hF9) | (model[7] & 8'h06);
      else model[t] = v;
    end
  endtask

  function automatic logic [31:0] model_dword(input int row);
    return {model[4*row+3], model[4*row+2], model[4*row+1], model[4*row]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_size = 2'(sz); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, sz, d);
  endtask

  task automatic do_read(input int a, output logic [31:0] q);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'(a);
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    logic [31:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 32'h0);

    // R1: every dword after reset
    for (int row = 0; row < 64; row++) begin
      do_read(row*4 + (row % 4), q);
      check("R1", q, model_dword(row));
    end

    // single-byte sweep, rule named by target byte
    for (int a = 0; a < 256; a++) begin
      do_write(a, 0, {24'hDEAD00, 8'(a ^ 8'hA5)});
      do_read(a, q);
      check(tag_of(a), q, model_dword(a/4));
    end

    // explicit masking corners
    do_write(5, 0, 32'hFF);   do_read(4, q); check("R3", q, model_dword(1));
    do_write(7, 0, 32'hFF);   do_read(4, q); check("R5", q, model_dword(1));
    do_write(7, 0, 32'h00);   do_read(4, q); check("R5", q, model_dword(1));
    do_write(6, 0, 32'hFF);   do_read(4, q); check("R4", q, model_dword(1));

    // word sweep at every start address
    for (int a = 0; a < 256; a++) begin
      do_write(a, 1, {8'h77, 8'h66, 8'(a*3), 8'(a+1)});
      do_read(a, q);
      check(a == 255 ? "R8" : "R7", q, model_dword(a/4));
      do_read((a+1) % 256, q);
      check(a == 255 ? "R8" : "R7", q, model_dword(((a+1) % 256)/4));
    end

    // dword sweep at every start address
    for (int a = 0; a < 256; a++) begin
      do_write(a, 2, {8'(a ^ 8'h3C), 8'(~a), 8'(a*5), 8'(a+7)});
      do_read(a, q);
      check(a > 252 ? "R8" : "R7", q, model_dword(a/4));
      do_read((a+3) % 256, q);
      check(a > 252 ? "R8" : "R7", q, model_dword(((a+3) % 256)/4));
    end

    // R8: nothing wrapped into the low dwords
    for (int row = 0; row < 64; row++) begin
      do_read(row*4, q);
      check("R8 full readback", q, model_dword(row));
    end

    // R7: size code 11 writes nothing
    do_write('h40, 3, 32'hFFFF_FFFF);
    do_read('h40, q);
    check("R7 size 11", q, model_dword('h10));
    do_write('hFE, 3, 32'h1234_5678);
    do_read('hFC, q);
    check("R7 size 11", q, model_dword('h3F));

    // R9: hold while rd_en low
    do_read('h08, held);
    check("R9 read", held, model_dword(2));
    @(negedge clk);
    rd_addr = 8'h44;
    repeat (3) @(negedge clk);
    check("R9 hold", rd_data, held);

    // R10: read in same cycle as write returns old data
    held = model_dword('h14);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h50; wr_size = 2'b10; wr_data = 32'hCAFE_F00D;
    rd_en = 1'b1; rd_addr = 8'h50;
    @(negedge clk);
    wr_en = 1'b0;
    model_write('h50, 2, 32'hCAFE_F00D);
    check("R10 same cycle old", rd_data, held);
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 next cycle new", rd_data, 32'hCAFE_F00D);

    finish_run();
  end

endmodule